// File: doc/BRIEF.md
# Single-Cycle Unaligned Byte Memory

This block is a byte-addressable memory with a 32-bit data path, built from four independent byte-wide banks. A byte address selects a row (the upper bits) and a byte offset within that row (the two lowest bits). The memory serves word, halfword and byte reads and writes at any byte address in a single access, including words and halfwords that cross from one row into the next.

Each bank has its own row input. The address generator gives every bank either the base row or the base row incremented by one. The choice depends only on the bank index and the byte offset. Write bytes are rotated onto their banks, and only the banks covered by the access size are enabled. Read bytes come back from the banks in bank order, so a rotator puts them back into address order.

Each bank is a synchronous RAM, so a response appears one cycle after its request. An access that would need a row beyond the last row is flagged as an error and has no effect on the memory.

Top module: `quad_bank_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` and `rsp_err` are 0.
- R2: Bank b (b = 0..3, holding byte address 4*row+b) uses row base+1 when b is less than the byte offset `req_addr[1:0]`, and row base otherwise. As a result, an access that crosses a row boundary still completes in one access.
- R3: A word read (`req_size` = 2, or the spare code 3, which behaves the same) returns, for every offset, the bytes at addresses A, A+1, A+2 and A+3 in `rsp_rdata[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` respectively.
- R4: A halfword read (`req_size` = 1) returns bytes A and A+1 in `rsp_rdata[31:24]` and `[23:16]`, and 0 in `rsp_rdata[15:0]`. This includes offset 3, which crosses into the next row.
- R5: A byte read (`req_size` = 0) returns byte A in `rsp_rdata[31:24]` and 0 in the rest.
- R6: A write stores `req_wdata[31-8i -: 8]` at address A+i for every i below the access size (1, 2 or 4 bytes). All other bytes keep their values.
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the read data reflects every write accepted before that request.
- R8: An access whose last byte lies beyond the final byte of the array sets `rsp_err`. It writes nothing, and its `rsp_rdata` is 0.
- R9: The response to a write, and any response while `rsp_valid` is low, has `rsp_rdata` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ROW_AW+2 | Byte address |
| req_wdata | input | 32 | Write bytes, first byte in [31:24] |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access ran past the last row |
| rsp_rdata | output | 32 | Read bytes in address order, uncovered bytes 0 |

## Verification
The bench builds the memory with ROW_AW = 4, which gives sixteen rows and 64 bytes. With so few rows, random addresses land in the top row often, so both the crossing accesses that raise the error flag and those that stay legal are exercised many times. The small array also lets a full initial fill finish in sixteen writes. After that, random traffic keeps rewriting and re-reading the same bytes across every offset and size combination.

// File: rtl/quad_mem_pkg.sv
package quad_mem_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // Number of bytes touched by a size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Position within the access of the byte that bank b holds.
  function automatic logic [1:0] lane_of_bank(input logic [1:0] bank, input logic [1:0] off);
    return bank - off;
  endfunction

  // True when the access runs into the following row.
  function automatic logic crosses_row(input logic [1:0] off, input logic [2:0] nbytes);
    return ({1'b0, off} + nbytes) > 3'd4;
  endfunction

endpackage

// File: rtl/qm_bank.sv
module qm_bank #(
  parameter int unsigned ROW_AW = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_AW-1:0] row,
  input  logic [7:0]        wbyte,
  output logic [7:0]        q
);
  localparam int unsigned ROWS = 1 << ROW_AW;

  logic [7:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[row] <= wbyte;
      q <= cells[row];
    end
  end
endmodule

// File: rtl/qm_addr_gen.sv
module qm_addr_gen
  import quad_mem_pkg::*;
#(
  parameter int unsigned ROW_AW = 8,
  localparam int unsigned ADDR_W = ROW_AW + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_size,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  output logic [LANES-1:0][ROW_AW-1:0] bank_row,
  output logic [LANES-1:0]            bank_en,
  output logic [LANES-1:0]            bank_we,
  output logic [LANES-1:0][7:0]       bank_wbyte,
  output logic                        acc_err
);
  logic [1:0]        off;
  logic [ROW_AW-1:0] base;
  logic [2:0]        nbytes;
  logic [LANES-1:0]  plus_vec;   // banks taking base+1
  logic [LANES-1:0]  lane_cov;   // banks covered by the access

  assign off    = req_addr[1:0];
  assign base   = req_addr[ADDR_W-1:2];
  assign nbytes = size_bytes(req_size);
  assign acc_err = req_valid && crosses_row(off, nbytes) && (&base);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0] lane;
    assign lane          = lane_of_bank(2'(b), off);
    assign plus_vec[b]   = (2'(b) < off);
    assign lane_cov[b]   = ({1'b0, lane} < nbytes);
    assign bank_row[b]   = base + ROW_AW'(plus_vec[b]);
    assign bank_en[b]    = req_valid;
    assign bank_we[b]    = req_valid && req_write && lane_cov[b] && !acc_err;
    assign bank_wbyte[b] = req_wdata[{(2'd3 - lane), 3'b000} +: 8];
  end

  // R2: the incremented banks are exactly as many as the byte offset
  assert_plus_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(plus_vec) == 32'(off)));

  // R6: enabled write lanes match the access size
  assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !acc_err) |-> ($countones(bank_we) == 32'(nbytes)));

  // R8: a faulting access writes no bank
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (bank_we == '0));
endmodule

// File: rtl/qm_rotator.sv
module qm_rotator
  import quad_mem_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [1:0]            req_off,
  input  logic                  req_err,
  input  logic [LANES-1:0][7:0] bank_q,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_rdata
);
  logic       rd_q;
  logic [1:0] off_q;
  logic [2:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_q      <= 1'b0;
      off_q     <= '0;
      n_q       <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && req_err;
      rd_q      <= req_valid && !req_write && !req_err;
      off_q     <= req_off;
      n_q       <= size_bytes(req_size);
    end
  end

  always_comb begin
    rsp_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rsp_valid && rd_q && (3'(i) < n_q))
        rsp_rdata[8*(3-i) +: 8] = bank_q[off_q + 2'(i)];
    end
  end

  // R9: write and idle responses carry no data
  assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid || !rd_q) |-> (rsp_rdata == '0));

  // R8: error response carries no data
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: rtl/quad_bank_mem.sv
module quad_bank_mem
  import quad_mem_pkg::*;
#(
  parameter int unsigned ROW_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ROW_AW+1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  logic [LANES-1:0][ROW_AW-1:0] bank_row;
  logic [LANES-1:0]             bank_en;
  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][7:0]        bank_wbyte;
  logic [LANES-1:0][7:0]        bank_q;
  logic                         acc_err;

  qm_addr_gen #(.ROW_AW(ROW_AW)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .bank_row   (bank_row),
    .bank_en    (bank_en),
    .bank_we    (bank_we),
    .bank_wbyte (bank_wbyte),
    .acc_err    (acc_err)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    qm_bank #(.ROW_AW(ROW_AW)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .row   (bank_row[b]),
      .wbyte (bank_wbyte[b]),
      .q     (bank_q[b])
    );
  end

  qm_rotator u_rot (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_off   (req_addr[1:0]),
    .req_err   (acc_err),
    .bank_q    (bank_q),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  // R7: a response follows each request by exactly one cycle
  assert_rsp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R8: errors only appear on valid responses
  assert_err_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

// File: tb/test_quad_bank_mem.sv
module test_quad_bank_mem;
  localparam int ROW_AW = 4;
  localparam int NBYTES = 4 << ROW_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic [ROW_AW+1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_err;
  logic [31:0]       rsp_rdata;

  logic [7:0] model [NBYTES];
  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  quad_bank_mem #(.ROW_AW(ROW_AW)) i_quad_bank_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Caller stands at a falling edge; returns at the next falling edge.
  task automatic do_op(input string tag, input bit wr, input logic [1:0] sz,
                       input int addr, input logic [31:0] wd);
    int n;
    bit err;
    logic [31:0] exp_d;
    n = nb(sz);
    err = (addr + n) > NBYTES;
    exp_d = '0;
    if (!wr && !err)
      for (int i = 0; i < n; i++) exp_d[31-8*i -: 8] = model[addr+i];
    if (wr && !err)
      for (int i = 0; i < n; i++) model[addr+i] = wd[31-8*i -: 8];
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = (ROW_AW+2)'(addr);
    req_wdata = wd;
    @(negedge clk);
    chk(tag, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, err, exp_d});
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    chk(tag, {rsp_valid, rsp_err, rsp_rdata}, 34'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 in reset", {rsp_valid, rsp_err, 32'd0}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {rsp_valid, rsp_err, 32'd0}, 34'd0);

    // Fill every row with aligned word writes (R6, R9)
    for (int r = 0; r < NBYTES/4; r++) do_op("R6 R9 fill", 1'b1, 2'd2, 4*r, $urandom);
    idle("R7 idle after burst");

    // Word reads at each offset across a row boundary (R2, R3)
    for (int o = 0; o < 4; o++) do_op("R2 R3 word offset", 1'b0, 2'd2, 20 + o, 32'd0);
    do_op("R3 spare size code", 1'b0, 2'd3, 23, 32'd0);
    // Halfword and byte reads (R4, R5)
    for (int o = 0; o < 4; o++) do_op("R4 half offset", 1'b0, 2'd1, 8 + o, 32'd0);
    for (int o = 0; o < 4; o++) do_op("R5 byte offset", 1'b0, 2'd0, 12 + o, 32'd0);

    // Unaligned writes leave neighbours alone (R6)
    do_op("R6 unaligned word write", 1'b1, 2'd2, 30, 32'hA1B2C3D4);
    for (int a = 28; a < 36; a++) do_op("R6 neighbour byte", 1'b0, 2'd0, a, 32'd0);
    do_op("R6 half write crossing", 1'b1, 2'd1, 39, 32'h5E6F0000);
    do_op("R6 word readback", 1'b0, 2'd2, 37, 32'd0);
    do_op("R6 byte write", 1'b1, 2'd0, 41, 32'h99000000);
    do_op("R6 word readback", 1'b0, 2'd2, 40, 32'd0);

    // Top row: legal and faulting accesses (R8)
    do_op("R8 legal top word", 1'b0, 2'd2, NBYTES-4, 32'd0);
    do_op("R8 legal top half", 1'b1, 2'd1, NBYTES-2, 32'h1234FFFF);
    do_op("R8 fault word write", 1'b1, 2'd2, NBYTES-3, 32'hDEADBEEF);
    do_op("R8 fault half write", 1'b1, 2'd1, NBYTES-1, 32'hCAFE0000);
    do_op("R8 fault word read", 1'b0, 2'd2, NBYTES-1, 32'd0);
    do_op("R8 untouched after fault", 1'b0, 2'd2, NBYTES-4, 32'd0);
    do_op("R8 untouched row zero", 1'b0, 2'd2, 0, 32'd0);
    idle("R7 R9 idle");

    // Random mixed traffic (R2..R9)
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 15) == 0) idle("R7 random idle");
      else do_op("R2-mix random", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 int'($urandom_range(0, NBYTES-1)), $urandom);
    end
    idle("R7 final idle");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule